// File: doc/BRIEF.md
# Incremental Encoder Quadrature Decoder

This block turns the two phase signals and the index signal of an incremental rotary or linear encoder into a signed sense of motion and an absolute position. Each of the three inputs is first brought into the clock domain and cleaned of short glitches. A transition decoder then works out, for every legal edge, which way the shaft moved. It also emits a one-cycle strobe for each edge that the chosen resolution counts, and other logic can use that strobe to estimate velocity.

A 16-bit up/down position register tracks distance. The control inputs choose one of two ways to bound it. In period mode it wraps between zero and a programmable period value. In index mode it runs freely and is cleared by each rising edge of the index input. Two sticky flags report events to software: one for a reversal of direction and one for a reset of the position register. The reset flag is gated by an enable.

Top module: `qdec_top`

## Requirements
- R1: After a synchronous reset, `pos_count` is 0, `dir_up` is 1, and `dir_chg_flag`, `pos_irq_flag` and `count_strobe` are 0.
- R2: Each input passes through a two-flop synchroniser and a filter that accepts a new level only after the synchronised value has differed from the accepted level on 3 consecutive clocks. An input pulse that lasts 2 clocks has no effect on any output, and a pulse of 3 clocks is accepted.
- R3: The state {A,B} moving 00→10→11→01→00 (A leads B) is motion up, and the reverse order is motion down. `dir_up` takes the direction of every legal edge, counted or not.
- R4: With `cfg_x4`=1 every legal edge of A or B is counted. With `cfg_x4`=0 only edges of A are counted. Each counted edge gives exactly one one-cycle pulse on `count_strobe` and moves `pos_count` by one.
- R5: A step in which A and B change in the same clock is illegal: it gives no count, no strobe and no change of direction.
- R6: With `cfg_rst_on_index`=0 (period mode), counting up from a value at or above `cfg_period` gives 0, and counting down from 0 loads `cfg_period`. Both count as a counter reset.
- R7: With `cfg_rst_on_index`=1 (index mode), the counter wraps freely over 16 bits, ignores `cfg_period`, and clears to 0 on the rising edge of the filtered index. The index wins over a count in the same cycle. In period mode the index input has no effect on `pos_count`.
- R8: `dir_chg_flag` is set when a legal edge has a direction different from the current `dir_up`. It holds until `dir_chg_clr` is pulsed, and a set in the same cycle wins over the clear.
- R9: `pos_irq_flag` is set on any counter reset (R6 or R7) while `cfg_irq_en`=1, holds until `pos_irq_clr` is pulsed, and is never set while `cfg_irq_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_in | input | 1 | Encoder phase A, asynchronous |
| phase_b_in | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Encoder index, asynchronous |
| cfg_x4 | input | 1 | 1: count edges of A and B; 0: edges of A only |
| cfg_rst_on_index | input | 1 | 1: index mode; 0: period mode |
| cfg_period | input | 16 | Period value for period mode |
| cfg_irq_en | input | 1 | Enables setting of the position reset flag |
| dir_chg_clr | input | 1 | Clears the direction change flag |
| pos_irq_clr | input | 1 | Clears the position reset flag |
| pos_count | output | 16 | Position counter |
| dir_up | output | 1 | Direction of the last legal edge, 1 = up |
| dir_chg_flag | output | 1 | Sticky direction change flag |
| pos_irq_flag | output | 1 | Sticky position reset flag |
| count_strobe | output | 1 | One-cycle pulse per counted edge |

## Verification
The assertions assume that the period value does not change in the cycle it is compared against. The bounding check is therefore enabled only while `cfg_period` and the mode are stable. They also assume that the counter starts inside the period before that check applies. The stimulus changes configuration only while the encoder inputs are at rest, and it holds each encoder state for many more clocks than the filter needs. As a result, every edge reaches the decoder cleanly, and only the glitch tests use shorter pulses, on purpose.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned CNT_W = 16;

  typedef struct packed {
    logic legal;   // exactly one phase changed
    logic up;      // direction of that change
    logic count;   // change is counted at the chosen resolution
  } qstep_t;

  // Classify a change of the filtered phases.
  function automatic qstep_t classify(input logic a_now, input logic b_now,
                                      input logic a_old, input logic b_old,
                                      input logic x4);
    qstep_t s;
    logic   a_chg, b_chg;
    a_chg   = a_now ^ a_old;
    b_chg   = b_now ^ b_old;
    s.legal = a_chg ^ b_chg;
    s.up    = a_chg ? (a_now ^ b_now) : ~(a_now ^ b_now);
    s.count = s.legal & (a_chg | x4);
    return s;
  endfunction
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STABLE_LEN  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned RUN_W = $clog2(STABLE_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [RUN_W-1:0]       run_q;
  logic                   lvl_q;
  logic                   s_in;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  assign s_in = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (s_in == lvl_q) begin
      run_q <= '0;
    end else if (run_q == RUN_W'(STABLE_LEN - 1)) begin
      run_q <= '0;
      lvl_q <= s_in;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   a_f,
  input  logic   b_f,
  input  logic   idx_f,
  input  logic   x4,
  output qstep_t step,
  output logic   idx_rise
);
  logic a_q, b_q, idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      a_q   <= a_f;
      b_q   <= b_f;
      idx_q <= idx_f;
    end
  end

  assign step     = classify(a_f, b_f, a_q, b_q, x4);
  assign idx_rise = idx_f & ~idx_q;
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         do_count,
  input  logic         up,
  input  logic         idx_rise,
  input  logic         use_index,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         reset_evt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d     = cnt_q;
    reset_evt = 1'b0;
    if (use_index) begin
      if (idx_rise) begin
        cnt_d     = '0;
        reset_evt = 1'b1;
      end else if (do_count) begin
        cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end else if (do_count) begin
      if (up) begin
        if (cnt_q >= period) begin
          cnt_d     = '0;
          reset_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d     = period;
          reset_evt = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STABLE_LEN  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a_in,
  input  logic             phase_b_in,
  input  logic             index_in,
  input  logic             cfg_x4,
  input  logic             cfg_rst_on_index,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic             cfg_irq_en,
  input  logic             dir_chg_clr,
  input  logic             pos_irq_clr,
  output logic [CNT_W-1:0] pos_count,
  output logic             dir_up,
  output logic             dir_chg_flag,
  output logic             pos_irq_flag,
  output logic             count_strobe
);
  localparam int unsigned N_IN = 3;

  logic [N_IN-1:0] raw_in, filt;
  qstep_t          step;
  logic            idx_rise, reset_evt;
  logic            dir_q, chg_q, irq_q, stb_q;

  assign raw_in = {index_in, phase_b_in, phase_a_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_filt
    qdec_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .STABLE_LEN (STABLE_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_in[i]),
      .dout(filt[i])
    );
  end

  qdec_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .a_f     (filt[0]),
    .b_f     (filt[1]),
    .idx_f   (filt[2]),
    .x4      (cfg_x4),
    .step    (step),
    .idx_rise(idx_rise)
  );

  qdec_poscnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .do_count (step.count),
    .up       (step.up),
    .idx_rise (idx_rise),
    .use_index(cfg_rst_on_index),
    .period   (cfg_period),
    .cnt      (pos_count),
    .reset_evt(reset_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b1;
      chg_q <= 1'b0;
      irq_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      if (step.legal) dir_q <= step.up;
      chg_q <= (chg_q & ~dir_chg_clr) | (step.legal & (step.up != dir_q));
      irq_q <= (irq_q & ~pos_irq_clr) | (reset_evt & cfg_irq_en);
      stb_q <= step.count;
    end
  end

  assign dir_up       = dir_q;
  assign dir_chg_flag = chg_q;
  assign pos_irq_flag = irq_q;
  assign count_strobe = stb_q;
endmodule

// File: rtl/qdec_sva.sv
module qdec_sva
  import qdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_rst_on_index,
  input logic [CNT_W-1:0] cfg_period,
  input logic             cfg_irq_en,
  input logic [CNT_W-1:0] pos_count,
  input logic             dir_up,
  input logic             dir_chg_flag,
  input logic             pos_irq_flag,
  input logic             count_strobe
);
  AST_MOVE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos_count) |-> (count_strobe || pos_count == '0)); // R4

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (count_strobe && dir_up && $past(!cfg_rst_on_index) && !cfg_rst_on_index)
      |-> (pos_count == $past(pos_count) + 1'b1 || pos_count == '0)); // R6

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (count_strobe && !dir_up && $past(!cfg_rst_on_index) && !cfg_rst_on_index)
      |-> (pos_count == $past(pos_count) - 1'b1 || pos_count == $past(cfg_period))); // R6

  AST_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rst_on_index && $past(!cfg_rst_on_index) && $stable(cfg_period)
      && $past(pos_count) <= $past(cfg_period)) |-> pos_count <= cfg_period); // R6

  AST_DIR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_up) |-> dir_chg_flag); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(pos_irq_flag) |-> $past(cfg_irq_en)); // R9
endmodule

bind qdec_top qdec_sva u_sva (
  .clk             (clk),
  .rst             (rst),
  .cfg_rst_on_index(cfg_rst_on_index),
  .cfg_period      (cfg_period),
  .cfg_irq_en      (cfg_irq_en),
  .pos_count       (pos_count),
  .dir_up          (dir_up),
  .dir_chg_flag    (dir_chg_flag),
  .pos_irq_flag    (pos_irq_flag),
  .count_strobe    (count_strobe)
);

// File: tb/qdec_top_tb.sv
`timescale 1ns/1ps
module qdec_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa = 1'b0, pb = 1'b0, pi = 1'b0;
  logic        x4 = 1'b1, idxmode = 1'b0, irq_en = 1'b1;
  logic [15:0] period = 16'd5;
  logic        dclr = 1'b0, iclr = 1'b0;
  logic [15:0] cnt;
  logic        dir, dchg, irq, stb;

  int checks = 0;
  int errors = 0;
  int n_stb  = 0;

  always #2 clk = ~clk;

  qdec_top u_dut (
    .clk(clk), .rst(rst), .phase_a_in(pa), .phase_b_in(pb), .index_in(pi),
    .cfg_x4(x4), .cfg_rst_on_index(idxmode), .cfg_period(period),
    .cfg_irq_en(irq_en), .dir_chg_clr(dclr), .pos_irq_clr(iclr),
    .pos_count(cnt), .dir_up(dir), .dir_chg_flag(dchg),
    .pos_irq_flag(irq), .count_strobe(stb)
  );

  always @(negedge clk) if (!rst && stb) n_stb++;

  typedef struct packed {
    logic        a;
    logic        b;
    logic [15:0] cnt;
    logic        up;
  } vec_t;

  // x4, period 5, period mode, starting at state 00 and count 0
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 16'd1, 1'b1},
    '{1'b1, 1'b1, 16'd2, 1'b1},
    '{1'b0, 1'b1, 16'd3, 1'b1},
    '{1'b0, 1'b0, 16'd4, 1'b1},
    '{1'b1, 1'b0, 16'd5, 1'b1},
    '{1'b1, 1'b1, 16'd0, 1'b1},
    '{1'b0, 1'b1, 16'd1, 1'b1},
    '{1'b1, 1'b1, 16'd0, 1'b0},
    '{1'b1, 1'b0, 16'd5, 1'b0},
    '{1'b0, 1'b0, 16'd4, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    pa = a;
    pb = b;
    idle(12);
  endtask

  task automatic pulse_a(input int len);
    @(negedge clk);
    pa = 1'b1;
    idle(len);
    pa = 1'b0;
    idle(12);
  endtask

  task automatic pulse_idx;
    @(negedge clk);
    pi = 1'b1;
    idle(6);
    pi = 1'b0;
    idle(8);
  endtask

  task automatic pulse_clr(input logic which_irq);
    @(negedge clk);
    if (which_irq) iclr = 1'b1; else dclr = 1'b1;
    @(negedge clk);
    iclr = 1'b0;
    dclr = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    idle(4);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1", "count", cnt, 0);
    chk("R1", "dir", dir, 1);
    chk("R1", "dirflag", dchg, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "strobe", stb, 0);

    // R3 R4 R6 table walk in x4 period mode
    s0 = n_stb;
    for (int i = 0; i < 10; i++) begin
      set_ab(VECS[i].a, VECS[i].b);
      chk("R6", $sformatf("count row %0d", i), cnt, VECS[i].cnt);
      chk("R3", $sformatf("dir row %0d", i), dir, VECS[i].up);
    end
    chk("R4", "strobes x4", n_stb - s0, 10);
    chk("R9", "irq after wraps", irq, 1);
    chk("R8", "dir flag after reversal", dchg, 1);
    pulse_clr(1'b0);
    chk("R8", "dir flag cleared", dchg, 0);
    pulse_clr(1'b1);
    chk("R9", "irq cleared", irq, 0);

    // R2 glitch rejection and acceptance
    s0 = n_stb;
    pulse_a(2);
    chk("R2", "2-clk pulse strobes", n_stb - s0, 0);
    chk("R2", "2-clk pulse count", cnt, 4);
    chk("R2", "2-clk pulse dir flag", dchg, 0);
    pulse_a(3);
    chk("R2", "3-clk pulse strobes", n_stb - s0, 2);
    chk("R2", "3-clk pulse count", cnt, 4);
    pulse_clr(1'b0);

    // R5 illegal double change
    s0 = n_stb;
    set_ab(1'b1, 1'b1);
    chk("R5", "illegal strobes", n_stb - s0, 0);
    chk("R5", "illegal count", cnt, 4);
    chk("R5", "illegal dir flag", dchg, 0);
    set_ab(1'b0, 1'b0);
    chk("R5", "illegal back count", cnt, 4);

    // R4 x2 mode
    @(negedge clk);
    x4 = 1'b0;
    period = 16'd100;
    s0 = n_stb;
    set_ab(1'b1, 1'b0);
    chk("R4", "x2 A edge", cnt, 5);
    set_ab(1'b1, 1'b1);
    chk("R4", "x2 B edge not counted", cnt, 5);
    chk("R3", "x2 B edge dir", dir, 1);
    set_ab(1'b0, 1'b1);
    set_ab(1'b0, 1'b0);
    chk("R4", "x2 full cycle", cnt, 6);
    chk("R4", "x2 strobes", n_stb - s0, 2);

    // R7 index mode
    @(negedge clk);
    x4 = 1'b1;
    idxmode = 1'b1;
    period = 16'd2;
    irq_en = 1'b0;
    set_ab(1'b1, 1'b0);
    set_ab(1'b1, 1'b1);
    chk("R7", "free run past period", cnt, 8);
    pulse_idx();
    chk("R7", "index clears", cnt, 0);
    chk("R9", "irq disabled", irq, 0);
    @(negedge clk);
    irq_en = 1'b1;
    set_ab(1'b0, 1'b1);
    chk("R7", "count after index", cnt, 1);
    pulse_idx();
    chk("R7", "index clears again", cnt, 0);
    chk("R9", "irq on index", irq, 1);
    set_ab(1'b1, 1'b1);
    chk("R7", "16-bit wrap down", cnt, 16'hFFFF);
    pulse_idx();
    pulse_clr(1'b1);

    // R7 index ignored in period mode
    @(negedge clk);
    idxmode = 1'b0;
    period = 16'd100;
    set_ab(1'b0, 1'b1);
    chk("R6", "period mode step", cnt, 1);
    pulse_idx();
    chk("R7", "index ignored", cnt, 1);
    chk("R9", "no irq from index", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule